// File: doc/BRIEF.md
# SerDes Lane Override Sequencer

This block drives the per-lane register changes that a PHY lane needs after a link hard reset. It talks to a separate register access engine through a simple command port. Each command carries a read/write flag, an address and write data. The engine answers each command with a one-cycle done pulse and, for reads, the read data. The sequencer computes each lane's register addresses from a fixed base plus the lane number times 0x100.

An override run is started with `start_i`. It first polls the lane's receive status until the half-rate flag clears, giving up after a bounded number of polls. It then forces the receive DPLL mode and pulses the DPLL reset. Last, it forces the transmit attenuation. Every change is a read-modify-write of a private working word. The usual mode value applied after a link reset is 3. A separate command, `disable_i`, only clears the receive override. `done_o` pulses once when the final command of either sequence has completed.

Top module: `lane_ovr_seq`

## Requirements
- R1: Command addresses are base + lane*0x100, with bases 0x2001 (TX status), 0x2002 (RX status), 0x2004 (TX override) and 0x2005 (RX override). Every command address has bits 15:10 equal to 6'b001000 and a low byte of 0x01, 0x02, 0x04 or 0x05.
- R2: After `start_i`, RX status is read again and again while read data bit 0 (half-rate) is 1. The first read with bit 0 clear ends the polling.
- R3: Polling stops after MAX_POLLS reads (default 1000) even if bit 0 is still set, and the sequence then continues.
- R4: The override sequence then reads RX status into a working word W. It writes W with bit 14 cleared to RX override, then writes it with bit 14 set.
- R5: Next, bits 10:8 of W are replaced by the DPLL mode and W is written. Then bit 11 is set and W is written. Then bit 11 is cleared and W is written, all to RX override.
- R6: Last, TX status is read into W. W is written to TX override with bit 15 cleared, then with bit 15 set, then with the 3-bit attenuation ORed into bits 12:10. That makes 10 commands after the polls.
- R7: `disable_i` reads RX status and writes that value with bit 14 cleared to RX override. Those two commands end the sequence.
- R8: `cmd_valid_o` stays high, with address, write flag and write data stable, until `cmd_done_i`. It is low in the cycle after each done, so one command is never issued before the previous one completes.
- R9: `done_o` is a one-cycle pulse in the cycle after the last command's done. While a sequence runs, `start_i` and `disable_i` are ignored. If both are high at once in idle, `start_i` wins. No command follows `done_o` until a new request arrives.
- R10: During and right after reset, `cmd_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start the full override sequence (sampled in idle) |
| disable_i | input | 1 | Start the RX override disable sequence (sampled in idle) |
| lane_i | input | LANE_W | Lane number |
| atten_i | input | 3 | Transmit attenuation value |
| dpll_mode_i | input | 3 | Receive DPLL mode value |
| cmd_valid_o | output | 1 | Command request to the access engine |
| cmd_write_o | output | 1 | 1 = write, 0 = read |
| cmd_addr_o | output | ADDR_W | Register address |
| cmd_wdata_o | output | DATA_W | Write data (zero on reads) |
| cmd_done_i | input | 1 | One-cycle completion pulse from the engine |
| cmd_rdata_i | input | DATA_W | Read data, valid with cmd_done_i |
| done_o | output | 1 | Sequence finished pulse |

## Verification
The hardest case to reach is the poll limit. The lane has to report half-rate on every one of a thousand consecutive reads, and the sequence must still go on with a status word whose half-rate bit is set. The bench's engine model takes a count of status reads that should report half-rate. Setting that count above the limit holds the flag for the whole poll window and one read beyond it. A second hard case is a request that arrives mid-sequence. The bench raises both requests, with a different lane, partway through a run and checks that the command trace is unchanged.

// File: rtl/lane_ovr_pkg.sv
package lane_ovr_pkg;

  localparam int unsigned FIELD_W      = 3;
  localparam int unsigned BIT_HALF     = 0;
  localparam int unsigned DPLL_LSB     = 8;
  localparam int unsigned ATTEN_LSB    = 10;
  localparam int unsigned BIT_DPLL_RST = 11;
  localparam int unsigned BIT_RX_OVR   = 14;
  localparam int unsigned BIT_TX_OVR   = 15;
  localparam int unsigned LANE_SHIFT   = 8;

  localparam logic [15:0] BASE_TX_STS = 16'h2001;
  localparam logic [15:0] BASE_RX_STS = 16'h2002;
  localparam logic [15:0] BASE_TX_OVR = 16'h2004;
  localparam logic [15:0] BASE_RX_OVR = 16'h2005;

  typedef enum logic [1:0] {REG_TX_STS, REG_RX_STS, REG_TX_OVR, REG_RX_OVR} reg_sel_e;

  typedef enum logic [3:0] {
    OP_LOAD, OP_CLR_RXO, OP_SET_RXO, OP_MODE, OP_SET_RST,
    OP_CLR_RST, OP_CLR_TXO, OP_SET_TXO, OP_ATTEN
  } word_op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_GAP} seq_state_e;

  typedef struct packed {
    logic     wr;
    reg_sel_e sel;
    word_op_e op;
    logic     poll;
    logic     last;
  } step_t;

  localparam logic [3:0] STEP_OVR_FIRST = 4'd0;
  localparam logic [3:0] STEP_DIS_FIRST = 4'd11;

  // micro-program: 0..10 override, 11..12 disable
  function automatic step_t step_decode(input logic [3:0] idx);
    step_t s;
    s = '{wr: 1'b0, sel: REG_RX_STS, op: OP_LOAD, poll: 1'b0, last: 1'b1};
    case (idx)
      4'd0:  s = '{wr: 1'b0, sel: REG_RX_STS, op: OP_LOAD,    poll: 1'b1, last: 1'b0};
      4'd1:  s = '{wr: 1'b0, sel: REG_RX_STS, op: OP_LOAD,    poll: 1'b0, last: 1'b0};
      4'd2:  s = '{wr: 1'b1, sel: REG_RX_OVR, op: OP_CLR_RXO, poll: 1'b0, last: 1'b0};
      4'd3:  s = '{wr: 1'b1, sel: REG_RX_OVR, op: OP_SET_RXO, poll: 1'b0, last: 1'b0};
      4'd4:  s = '{wr: 1'b1, sel: REG_RX_OVR, op: OP_MODE,    poll: 1'b0, last: 1'b0};
      4'd5:  s = '{wr: 1'b1, sel: REG_RX_OVR, op: OP_SET_RST, poll: 1'b0, last: 1'b0};
      4'd6:  s = '{wr: 1'b1, sel: REG_RX_OVR, op: OP_CLR_RST, poll: 1'b0, last: 1'b0};
      4'd7:  s = '{wr: 1'b0, sel: REG_TX_STS, op: OP_LOAD,    poll: 1'b0, last: 1'b0};
      4'd8:  s = '{wr: 1'b1, sel: REG_TX_OVR, op: OP_CLR_TXO, poll: 1'b0, last: 1'b0};
      4'd9:  s = '{wr: 1'b1, sel: REG_TX_OVR, op: OP_SET_TXO, poll: 1'b0, last: 1'b0};
      4'd10: s = '{wr: 1'b1, sel: REG_TX_OVR, op: OP_ATTEN,   poll: 1'b0, last: 1'b1};
      4'd11: s = '{wr: 1'b0, sel: REG_RX_STS, op: OP_LOAD,    poll: 1'b0, last: 1'b0};
      4'd12: s = '{wr: 1'b1, sel: REG_RX_OVR, op: OP_CLR_RXO, poll: 1'b0, last: 1'b1};
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lane_ovr_addr.sv
module lane_ovr_addr
  import lane_ovr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANE_W = 2
) (
  input  reg_sel_e            sel_i,
  input  logic [LANE_W-1:0]   lane_i,
  output logic [ADDR_W-1:0]   addr_o
);
  logic [ADDR_W-1:0] base;

  always_comb begin
    case (sel_i)
      REG_TX_STS: base = ADDR_W'(BASE_TX_STS);
      REG_RX_STS: base = ADDR_W'(BASE_RX_STS);
      REG_TX_OVR: base = ADDR_W'(BASE_TX_OVR);
      default:    base = ADDR_W'(BASE_RX_OVR);
    endcase
  end

  assign addr_o = base + (ADDR_W'(lane_i) << LANE_SHIFT);
endmodule

// File: rtl/lane_ovr_alu.sv
module lane_ovr_alu
  import lane_ovr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  word_op_e             op_i,
  input  logic [DATA_W-1:0]    word_i,
  input  logic [FIELD_W-1:0]   mode_i,
  input  logic [FIELD_W-1:0]   atten_i,
  output logic [DATA_W-1:0]    word_o
);
  localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);
  localparam logic [DATA_W-1:0] RXO_M    = ONE << BIT_RX_OVR;
  localparam logic [DATA_W-1:0] TXO_M    = ONE << BIT_TX_OVR;
  localparam logic [DATA_W-1:0] RST_M    = ONE << BIT_DPLL_RST;
  localparam logic [DATA_W-1:0] FIELD_M  = DATA_W'((1 << FIELD_W) - 1);
  localparam logic [DATA_W-1:0] DPLL_M   = FIELD_M << DPLL_LSB;

  always_comb begin
    case (op_i)
      OP_CLR_RXO: word_o = word_i & ~RXO_M;
      OP_SET_RXO: word_o = word_i | RXO_M;
      OP_MODE:    word_o = (word_i & ~DPLL_M) | ((DATA_W'(mode_i) & FIELD_M) << DPLL_LSB);
      OP_SET_RST: word_o = word_i | RST_M;
      OP_CLR_RST: word_o = word_i & ~RST_M;
      OP_CLR_TXO: word_o = word_i & ~TXO_M;
      OP_SET_TXO: word_o = word_i | TXO_M;
      // attenuation masked to its field width before shifting
      OP_ATTEN:   word_o = word_i | ((DATA_W'(atten_i) & FIELD_M) << ATTEN_LSB);
      default:    word_o = word_i;
    endcase
  end
endmodule

// File: rtl/lane_ovr_poll.sv
module lane_ovr_poll #(
  parameter int MAX_POLLS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // high while the read in flight is the MAX_POLLS-th poll
  assign last_o = (cnt_q == CNT_W'(MAX_POLLS - 1));
endmodule

// File: rtl/lane_ovr_seq.sv
module lane_ovr_seq
  import lane_ovr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int LANE_W    = 2,
  parameter int MAX_POLLS = 1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                disable_i,
  input  logic [LANE_W-1:0]   lane_i,
  input  logic [FIELD_W-1:0]  atten_i,
  input  logic [FIELD_W-1:0]  dpll_mode_i,
  output logic                cmd_valid_o,
  output logic                cmd_write_o,
  output logic [ADDR_W-1:0]   cmd_addr_o,
  output logic [DATA_W-1:0]   cmd_wdata_o,
  input  logic                cmd_done_i,
  input  logic [DATA_W-1:0]   cmd_rdata_i,
  output logic                done_o
);
  seq_state_e           state_q;
  logic [3:0]           step_q;
  logic [LANE_W-1:0]    lane_q;
  logic [FIELD_W-1:0]   atten_q;
  logic [FIELD_W-1:0]   mode_q;
  logic [DATA_W-1:0]    word_q;
  logic                 done_q;
  step_t                step_cur;
  logic [DATA_W-1:0]    alu_word;
  logic                 poll_last;
  logic                 repoll;
  logic                 req_done;

  assign step_cur = step_decode(step_q);
  assign req_done = (state_q == ST_REQ) && cmd_done_i;
  assign repoll   = step_cur.poll && cmd_rdata_i[BIT_HALF] && !poll_last;

  lane_ovr_addr #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_addr (
    .sel_i  (step_cur.sel),
    .lane_i (lane_q),
    .addr_o (cmd_addr_o)
  );

  lane_ovr_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (step_cur.op),
    .word_i  (word_q),
    .mode_i  (mode_q),
    .atten_i (atten_q),
    .word_o  (alu_word)
  );

  lane_ovr_poll #(.MAX_POLLS(MAX_POLLS)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  ((state_q == ST_IDLE) && start_i),
    .inc_i  (req_done && repoll),
    .last_o (poll_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      lane_q  <= '0;
      atten_q <= '0;
      mode_q  <= '0;
      word_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_REQ;
            step_q  <= STEP_OVR_FIRST;
            lane_q  <= lane_i;
            atten_q <= atten_i;
            mode_q  <= dpll_mode_i;
          end else if (disable_i) begin
            state_q <= ST_REQ;
            step_q  <= STEP_DIS_FIRST;
            lane_q  <= lane_i;
          end
        end
        ST_REQ: begin
          if (cmd_done_i) begin
            word_q <= step_cur.wr ? alu_word : cmd_rdata_i;
            if (repoll) begin
              state_q <= ST_GAP;
            end else if (step_cur.last) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              step_q  <= step_q + 4'd1;
              state_q <= ST_GAP;
            end
          end
        end
        ST_GAP:  state_q <= ST_REQ;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (state_q == ST_REQ);
  assign cmd_write_o = step_cur.wr;
  assign cmd_wdata_o = step_cur.wr ? alu_word : '0;
  assign done_o      = done_q;
endmodule

// File: rtl/lane_ovr_chk.sv
module lane_ovr_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_o,
  input logic              cmd_write_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [DATA_W-1:0] cmd_wdata_o,
  input logic              cmd_done_i,
  input logic              done_o
);
  p_hold_until_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_addr_o)
                                   && $stable(cmd_write_o) && $stable(cmd_wdata_o));

  p_gap_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_done_i |=> !cmd_valid_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_valid_o);

  p_addr_map_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_addr_o[15:10] == 6'b001000) &&
                    (cmd_addr_o[7:0] == 8'h01 || cmd_addr_o[7:0] == 8'h02 ||
                     cmd_addr_o[7:0] == 8'h04 || cmd_addr_o[7:0] == 8'h05));

  p_reset_quiet_r10: assert property (@(posedge clk_i)
    !rst_ni |-> !cmd_valid_o && !done_o);
endmodule

bind lane_ovr_seq lane_ovr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_o (cmd_valid_o),
  .cmd_write_o (cmd_write_o),
  .cmd_addr_o  (cmd_addr_o),
  .cmd_wdata_o (cmd_wdata_o),
  .cmd_done_i  (cmd_done_i),
  .done_o      (done_o)
);

// File: tb/lane_ovr_seq_tb_top.sv
module lane_ovr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;
  localparam int MAXP       = 1000;
  localparam int LOG_N      = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, disable_i = 1'b0;
  logic [1:0]  lane_i = '0;
  logic [2:0]  atten_i = '0, mode_i = '0;
  logic        cmd_valid, cmd_write, cmd_done;
  logic [15:0] cmd_addr, cmd_wdata, cmd_rdata;
  logic        done;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  lane_ovr_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .disable_i(disable_i),
    .lane_i(lane_i), .atten_i(atten_i), .dpll_mode_i(mode_i),
    .cmd_valid_o(cmd_valid), .cmd_write_o(cmd_write), .cmd_addr_o(cmd_addr),
    .cmd_wdata_o(cmd_wdata), .cmd_done_i(cmd_done), .cmd_rdata_i(cmd_rdata),
    .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // engine model
  logic [15:0] rx_base = '0, tx_base = '0;
  int          half_cfg = 0, rx_base_reads = 0;
  int          rx_reads = 0, n_log = 0, lat_cnt = 0;
  logic        log_wr   [LOG_N];
  logic [15:0] log_addr [LOG_N];
  logic [15:0] log_data [LOG_N];

  initial begin cmd_done = 1'b0; cmd_rdata = '0; end

  always @(posedge clk) begin
    logic [15:0] v;
    cmd_done <= 1'b0;
    if (rst_n && cmd_valid && !cmd_done) begin
      if (lat_cnt == LAT) begin
        lat_cnt = 0;
        v = 16'hDEAD;
        if (!cmd_write) begin
          if (cmd_addr[7:0] == 8'h02) begin
            v = ((rx_reads - rx_base_reads) < half_cfg) ? (rx_base | 16'h0001) : rx_base;
            rx_reads = rx_reads + 1;
          end else if (cmd_addr[7:0] == 8'h01) v = tx_base;
        end
        cmd_done  <= 1'b1;
        cmd_rdata <= v;
        if (n_log < LOG_N) begin
          log_wr[n_log]   = cmd_write;
          log_addr[n_log] = cmd_addr;
          log_data[n_log] = cmd_write ? cmd_wdata : v;
        end
        n_log = n_log + 1;
      end else lat_cnt = lat_cnt + 1;
    end else lat_cnt = 0;
  end

  // handshake and done monitor
  int   done_cnt = 0, hs_err = 0;
  logic pv = 0, pd = 0;
  logic [15:0] pa = '0;
  always @(negedge clk) begin
    if (done) done_cnt = done_cnt + 1;
    if (rst_n) begin
      if (pv && !pd && (!cmd_valid || cmd_addr != pa)) hs_err = hs_err + 1;
      if (pv && pd && cmd_valid) hs_err = hs_err + 1;
    end
    pv = cmd_valid; pd = cmd_done; pa = cmd_addr;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp = n_cmp + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_cmd(input string req, input int idx, input bit wr, input logic [15:0] a, input logic [15:0] d);
    chk(req, $sformatf("cmd[%0d]", idx), {log_wr[idx], log_addr[idx], log_data[idx]}, {wr, a, d});
  endtask

  task automatic wait_done(input int d0);
    for (int i = 0; i < 20000 && done_cnt == d0; i++) @(negedge clk);
  endtask

  task automatic run_override(input int lane, input int mode, input int att,
                              input logic [15:0] rx, input logic [15:0] tx,
                              input int h, input bit both, input bit poke);
    int l0, d0, p, ln;
    logic [15:0] v, w, t, rxs, rxo, txs, txo;
    int bad;
    @(negedge clk);
    rx_base = rx; tx_base = tx; half_cfg = h; rx_base_reads = rx_reads;
    l0 = n_log; d0 = done_cnt;
    lane_i = lane[1:0]; mode_i = mode[2:0]; atten_i = att[2:0];
    start_i = 1'b1; disable_i = both;
    @(negedge clk);
    start_i = 1'b0; disable_i = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1; disable_i = 1'b1; lane_i = 2'd3 - lane[1:0]; mode_i = 3'd0; atten_i = 3'd0;
      @(negedge clk);
      start_i = 1'b0; disable_i = 1'b0;
    end
    wait_done(d0);
    repeat (8) @(negedge clk);
    p   = (h + 1 < MAXP) ? h + 1 : MAXP;
    ln  = n_log - l0;
    rxs = 16'h2002 + 16'(lane) * 16'h0100;
    rxo = 16'h2005 + 16'(lane) * 16'h0100;
    txs = 16'h2001 + 16'(lane) * 16'h0100;
    txo = 16'h2004 + 16'(lane) * 16'h0100;
    chk("R9", "command count", 64'(ln), 64'(p + 10));
    chk("R9", "done pulses", 64'(done_cnt - d0), 64'd1);
    if (ln == p + 10) begin
      bad = 0;
      for (int i = 0; i < p; i++)
        if (log_wr[l0+i] !== 1'b0 || log_addr[l0+i] !== rxs) bad++;
      chk((h >= MAXP) ? "R3" : "R2", "poll reads of RX status", 64'(bad), 64'd0);
      v = (h > p) ? (rx | 16'h0001) : rx;
      chk_cmd("R4", l0+p, 1'b0, rxs, v);
      w = v & ~16'h4000;                           chk_cmd("R4", l0+p+1, 1'b1, rxo, w);
      w = w | 16'h4000;                            chk_cmd("R4", l0+p+2, 1'b1, rxo, w);
      w = (w & ~16'h0700) | (16'(mode) << 8);      chk_cmd("R5", l0+p+3, 1'b1, rxo, w);
      w = w | 16'h0800;                            chk_cmd("R5", l0+p+4, 1'b1, rxo, w);
      w = w & ~16'h0800;                           chk_cmd("R5", l0+p+5, 1'b1, rxo, w);
      chk_cmd("R6", l0+p+6, 1'b0, txs, tx);
      t = tx & ~16'h8000;                          chk_cmd("R6", l0+p+7, 1'b1, txo, t);
      t = t | 16'h8000;                            chk_cmd("R6", l0+p+8, 1'b1, txo, t);
      t = t | (16'(att) << 10);                    chk_cmd("R6", l0+p+9, 1'b1, txo, t);
      chk("R1", "TX override address", 64'(log_addr[l0+p+9]), 64'(txo));
    end
  endtask

  task automatic test_reset();
    chk("R10", "valid in reset", 64'(cmd_valid), 64'd0);
    chk("R10", "done in reset", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "valid after reset", 64'(cmd_valid), 64'd0);
    chk("R10", "no commands after reset", 64'(n_log), 64'd0);
  endtask

  task automatic test_disable();
    int l0, d0;
    @(negedge clk);
    rx_base = 16'h7FFE; half_cfg = 0; rx_base_reads = rx_reads;
    l0 = n_log; d0 = done_cnt;
    lane_i = 2'd2; disable_i = 1'b1;
    @(negedge clk);
    disable_i = 1'b0;
    wait_done(d0);
    repeat (8) @(negedge clk);
    chk("R7", "command count", 64'(n_log - l0), 64'd2);
    chk("R7", "done pulses", 64'(done_cnt - d0), 64'd1);
    if (n_log - l0 == 2) begin
      chk_cmd("R7", l0,   1'b0, 16'h2202, 16'h7FFE);
      chk_cmd("R7", l0+1, 1'b1, 16'h2205, 16'h3FFE);
    end
  endtask

  initial begin
    #1;
    test_reset();
    run_override(0, 3, 5, 16'h5A3C, 16'h1234, 2, 1'b0, 1'b0);   // R2 basic
    run_override(3, 6, 7, 16'hC0F0, 16'h9C00, 0, 1'b1, 1'b0);   // R1 lane 3, R9 start wins
    run_override(1, 3, 2, 16'h2468, 16'h0F0F, 5000, 1'b0, 1'b0);// R3 poll limit
    test_disable();                                              // R7
    run_override(1, 4, 1, 16'h0B00, 16'h7000, 1, 1'b0, 1'b1);   // R9 busy requests ignored
    chk("R8", "handshake violations", 64'(hs_err), 64'd0);
    summary();
    $finish;
  end
endmodule